// File: doc/BRIEF.md
# Configurable Streaming Pipe Endpoint

This block is one end of a streaming pipe. A producer writes words into it over a valid/ready handshake, and a consumer reads them out over a second valid/ready handshake. A small internal buffer sits between the two ports. The producer-facing ready is registered. Its `READY_LATENCY` parameter tells the producer how many cycles it may keep sending after ready falls. Beats sent inside that allowance are stored. A beat sent after the allowance has run out is discarded, and a sticky protocol-error flag is raised.

Parameters pick the variant. `USES_VALID` = 0 removes the valid qualifier, so every cycle with ready high counts as a transfer. `BACKPRESSURE` = 0 ties ready high; a beat that then meets a full buffer is dropped and sets a sticky overflow flag. Each word is made of `SYM_W`-bit symbols. On the read port the first symbol sits in the lowest-order bits by default. With `FIRST_SYM_HIGH` it sits in the highest-order bits. The reordering is pure wiring and adds no cycle.

Elaboration stops when `DATA_W` is not a multiple of `SYM_W`. It also stops when `USES_VALID` is 0 and either `MIN_CAP` or `READY_LATENCY` is non-zero. The buffer holds `MIN_CAP + READY_LATENCY + 1` words.

Top module: `pipe_endpoint`

## Requirements
- R1: While `rst` is high and in the cycle right after it falls, `out_valid`, `overflow` and `proto_err` are 0. When `BACKPRESSURE` = 1, `in_ready` is also 0 in those cycles.
- R2: Accepted words leave the read port in the order they were accepted, and none is lost.
- R3: With `BACKPRESSURE` = 1, `in_ready` is 1 in a cycle only if more than `READY_LATENCY` entries are free in that cycle. It falls in the cycle after an acceptance leaves `READY_LATENCY` or fewer entries free.
- R4: With `BACKPRESSURE` = 1, a beat presented in any of the first `READY_LATENCY` cycles in which `in_ready` is 0 is stored, and `proto_err` stays 0.
- R5: With `BACKPRESSURE` = 1, a beat presented after that allowance is discarded, and `proto_err` becomes 1 after the next clock edge and stays 1 until reset.
- R6: Symbol k of the write word is bits [k*SYM_W +: SYM_W]. On the read port it appears at symbol position k when `FIRST_SYM_HIGH` = 0, and at position NSYM-1-k when `FIRST_SYM_HIGH` = 1.
- R7: With `BACKPRESSURE` = 0, `in_ready` is 1 at all times, including during reset.
- R8: With `BACKPRESSURE` = 0, a beat arriving while the buffer is full is discarded, and `overflow` becomes 1 after the next clock edge and stays 1 until reset.
- R9: With `USES_VALID` = 0, every clock edge at which `in_ready` is 1 stores `in_data`, whatever the level of `in_valid`.
- R10: A stored word appears on `out_data` in the same cycle that `out_valid` rises. It stays on `out_data`, with `out_valid` held, until a cycle with `out_ready` high takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Producer word valid (ignored when USES_VALID = 0) |
| in_data | input | DATA_W | Producer word, symbol 0 in the low bits |
| in_ready | output | 1 | Registered acceptance indication to the producer |
| out_valid | output | 1 | A word is available to the consumer |
| out_data | output | DATA_W | Consumer word in the configured symbol order |
| out_ready | input | 1 | Consumer takes the word this cycle |
| overflow | output | 1 | Sticky: a beat was dropped on a full buffer (no-backpressure mode) |
| proto_err | output | 1 | Sticky: a beat arrived after the ready-latency allowance |

## Verification
The assertions assume that `out_ready` is driven to a known level every cycle. They also assume the producer may break the ready-latency allowance, because the block flags such a beat rather than excluding it. The admission and buffer checks therefore state only what the block guarantees under any producer behaviour: words are written only while the buffer has room, ready is high only while room exceeds the latency, and the error flags are sticky. The stimulus changes inputs only on the falling clock edge. It breaks the allowance exactly once, on purpose, and then drains the buffer to show that the extra beat is gone.

// File: rtl/pipe_ep_pkg.sv
package pipe_ep_pkg;

  // Entries needed so that every beat admitted inside the latency allowance fits.
  function automatic int unsigned buf_depth(input int unsigned min_cap,
                                            input int unsigned ready_lat);
    return min_cap + ready_lat + 1;
  endfunction

  // Pointer width that stays legal for a single-entry buffer.
  function automatic int unsigned ptr_bits(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/pipe_ep_fifo.sv
module pipe_ep_fifo
  import pipe_ep_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 3,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [CW-1:0]     count
);

  localparam int unsigned PW = ptr_bits(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr;

  // Storage carries no reset so it maps onto RAM resources.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(wr_en) - CW'(rd_en);
    end
  end

  assign rd_data = mem[rd_ptr];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (count < CW'(DEPTH))); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (count != '0)); // R10

endmodule

// File: rtl/pipe_ep_admit.sv
module pipe_ep_admit #(
  parameter int unsigned DEPTH         = 3,
  parameter int unsigned READY_LATENCY = 0,
  parameter bit          USES_VALID    = 1'b1,
  parameter bit          BACKPRESSURE  = 1'b1,
  localparam int unsigned CW           = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [CW-1:0] count,
  input  logic          rd_en,
  output logic          in_ready,
  output logic          wr_en,
  output logic          overflow,
  output logic          proto_err
);

  localparam int unsigned LW = $clog2(READY_LATENCY + 2);
  localparam logic [LW-1:0] LAT_MAX = LW'(READY_LATENCY);

  logic          rdy_q;
  logic [LW-1:0] lat_q;
  logic          beat, allowed, ovf_set, perr_set;
  logic [CW-1:0] free_now;
  logic [CW:0]   free_next;

  assign free_now = CW'(DEPTH) - count;

  generate
    if (USES_VALID) begin : g_valid
      assign beat = in_valid;
    end else begin : g_novalid
      assign beat = BACKPRESSURE ? rdy_q : 1'b1;
    end

    if (BACKPRESSURE) begin : g_bp
      assign allowed  = rdy_q || (lat_q < LAT_MAX);
      assign wr_en    = beat && allowed;
      assign perr_set = beat && !allowed;
      assign ovf_set  = 1'b0;
      assign in_ready = rdy_q;
    end else begin : g_nobp
      assign allowed  = (count != CW'(DEPTH));
      assign wr_en    = beat && allowed;
      assign perr_set = 1'b0;
      assign ovf_set  = beat && !allowed;
      assign in_ready = 1'b1;
    end
  endgenerate

  assign free_next = (CW+1)'(free_now) - (CW+1)'(wr_en) + (CW+1)'(rd_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q     <= 1'b0;
      lat_q     <= LAT_MAX;
      overflow  <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      rdy_q <= (free_next > (CW+1)'(READY_LATENCY));
      if (rdy_q)              lat_q <= '0;
      else if (lat_q != LAT_MAX) lat_q <= lat_q + 1'b1;
      if (ovf_set)  overflow  <= 1'b1;
      if (perr_set) proto_err <= 1'b1;
    end
  end

  AST_READY_NEEDS_ROOM: assert property (@(posedge clk) disable iff (rst)
    (BACKPRESSURE && in_ready) |-> (free_now > CW'(READY_LATENCY))); // R3
  AST_PERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow); // R8

endmodule

// File: rtl/pipe_ep_symord.sv
module pipe_ep_symord #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned SYM_W      = 8,
  parameter bit          FIRST_HIGH = 1'b0
) (
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  localparam int unsigned NSYM = DATA_W / SYM_W;

  generate
    for (genvar k = 0; k < NSYM; k++) begin : g_sym
      localparam int unsigned DST = FIRST_HIGH ? (NSYM - 1 - k) : k;
      assign dout[DST*SYM_W +: SYM_W] = din[k*SYM_W +: SYM_W];
    end
  endgenerate

endmodule

// File: rtl/pipe_endpoint.sv
module pipe_endpoint
  import pipe_ep_pkg::*;
#(
  parameter int unsigned DATA_W         = 32,
  parameter int unsigned SYM_W          = 8,
  parameter int unsigned MIN_CAP        = 2,
  parameter int unsigned READY_LATENCY  = 0,
  parameter bit          USES_VALID     = 1'b1,
  parameter bit          BACKPRESSURE   = 1'b1,
  parameter bit          FIRST_SYM_HIGH = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  output logic              overflow,
  output logic              proto_err
);

  localparam int unsigned DEPTH = buf_depth(MIN_CAP, READY_LATENCY);
  localparam int unsigned CW    = $clog2(DEPTH + 1);

  generate
    if (SYM_W == 0 || (DATA_W % SYM_W) != 0) begin : g_bad_sym
      $error("pipe_endpoint: DATA_W must be a whole multiple of SYM_W");
    end
    if (!USES_VALID && (MIN_CAP != 0 || READY_LATENCY != 0)) begin : g_bad_nv
      $error("pipe_endpoint: without valid, MIN_CAP and READY_LATENCY must be 0");
    end
  endgenerate

  logic              wr_en, rd_en;
  logic [CW-1:0]     count;
  logic [DATA_W-1:0] stored;

  pipe_ep_admit #(
    .DEPTH(DEPTH), .READY_LATENCY(READY_LATENCY),
    .USES_VALID(USES_VALID), .BACKPRESSURE(BACKPRESSURE)
  ) u_admit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .count(count), .rd_en(rd_en),
    .in_ready(in_ready), .wr_en(wr_en), .overflow(overflow), .proto_err(proto_err)
  );

  pipe_ep_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(in_data),
    .rd_en(rd_en), .rd_data(stored), .count(count)
  );

  pipe_ep_symord #(.DATA_W(DATA_W), .SYM_W(SYM_W), .FIRST_HIGH(FIRST_SYM_HIGH)) u_ord (
    .din(stored), .dout(out_data)
  );

  assign out_valid = (count != '0);
  assign rd_en     = out_valid && out_ready;

  AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R10

endmodule

// File: tb/pipe_endpoint_test.sv
module pipe_endpoint_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Instance A: backpressure, latency 2, first symbol high, depth 5
  logic        a_valid = 0, a_ordy = 0, a_rdy, a_ovalid, a_ovf, a_perr;
  logic [31:0] a_data = '0, a_odata;
  // Instance B: no backpressure, little-endian, depth 2
  logic        b_valid = 0, b_ordy = 0, b_rdy, b_ovalid, b_ovf, b_perr;
  logic [15:0] b_data = '0, b_odata;
  // Instance C: no valid, depth 1
  logic        c_valid = 0, c_ordy = 0, c_rdy, c_ovalid, c_ovf, c_perr;
  logic [15:0] c_data = '0, c_odata;

  pipe_endpoint #(.DATA_W(32), .SYM_W(8), .MIN_CAP(2), .READY_LATENCY(2),
    .USES_VALID(1), .BACKPRESSURE(1), .FIRST_SYM_HIGH(1)) uut (
    .clk(clk), .rst(rst), .in_valid(a_valid), .in_data(a_data), .in_ready(a_rdy),
    .out_valid(a_ovalid), .out_data(a_odata), .out_ready(a_ordy),
    .overflow(a_ovf), .proto_err(a_perr));

  pipe_endpoint #(.DATA_W(16), .SYM_W(8), .MIN_CAP(1), .READY_LATENCY(0),
    .USES_VALID(1), .BACKPRESSURE(0), .FIRST_SYM_HIGH(0)) uut_nb (
    .clk(clk), .rst(rst), .in_valid(b_valid), .in_data(b_data), .in_ready(b_rdy),
    .out_valid(b_ovalid), .out_data(b_odata), .out_ready(b_ordy),
    .overflow(b_ovf), .proto_err(b_perr));

  pipe_endpoint #(.DATA_W(16), .SYM_W(4), .MIN_CAP(0), .READY_LATENCY(0),
    .USES_VALID(0), .BACKPRESSURE(1), .FIRST_SYM_HIGH(0)) uut_nv (
    .clk(clk), .rst(rst), .in_valid(c_valid), .in_data(c_data), .in_ready(c_rdy),
    .out_valid(c_ovalid), .out_data(c_odata), .out_ready(c_ordy),
    .overflow(c_ovf), .proto_err(c_perr));

  // {write word, expected read word} for the first-symbol-high instance
  localparam logic [63:0] VEC [4] = '{
    {32'h4433_2211, 32'h1122_3344},
    {32'hA1B2_C3D4, 32'hD4C3_B2A1},
    {32'h0000_00FF, 32'hFF00_0000},
    {32'h1234_5678, 32'h7856_3412}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
  endtask

  initial begin
    // ---- Instance A ----
    @(negedge clk);
    do_reset();
    chk("R1 a in_ready", a_rdy, 0);
    chk("R1 a out_valid", a_ovalid, 0);
    chk("R1 a proto_err", a_perr, 0);
    chk("R1 a overflow", a_ovf, 0);

    for (int i = 0; i < 4; i++) begin
      @(negedge clk); a_valid = 1; a_data = VEC[i][63:32]; a_ordy = 0;
      @(negedge clk); a_valid = 0;
      chk("R10 a valid", a_ovalid, 1);
      chk("R6 a order", a_odata, VEC[i][31:0]);
      @(negedge clk);
      chk("R10 a hold", a_odata, VEC[i][31:0]);
      a_ordy = 1;
      @(negedge clk); a_ordy = 0;
      chk("R2 a empty", a_ovalid, 0);
    end

    chk("R3 a ready room", a_rdy, 1);
    for (int k = 1; k <= 6; k++) begin
      a_valid = 1; a_data = 32'(k);
      @(negedge clk);
      if (k == 2) chk("R3 a still ready", a_rdy, 1);
      if (k == 3) chk("R3 a ready drop", a_rdy, 0);
      if (k == 5) chk("R4 a window ok", a_perr, 0);
      if (k == 6) chk("R5 a late beat", a_perr, 1);
    end
    a_valid = 0; a_ordy = 1;
    for (int k = 1; k <= 5; k++) begin
      chk("R2 a drain valid", a_ovalid, 1);
      chk("R4 a drain data", a_odata, 32'(k) << 24);
      @(negedge clk);
    end
    a_ordy = 0;
    chk("R5 a discarded", a_ovalid, 0);
    chk("R5 a sticky", a_perr, 1);
    chk("R3 a ready back", a_rdy, 1);

    // ---- Instance B ----
    rst = 1'b1; #1;
    chk("R7 b ready in reset", b_rdy, 1);
    do_reset();
    chk("R7 b ready", b_rdy, 1);
    chk("R1 b overflow", b_ovf, 0);
    b_valid = 1; b_data = 16'hA1B2; @(negedge clk);
    b_data = 16'hC3D4; @(negedge clk);
    chk("R8 b no ovf yet", b_ovf, 0);
    b_data = 16'hE5F6; @(negedge clk);
    b_valid = 0;
    chk("R8 b ovf", b_ovf, 1);
    chk("R7 b ready full", b_rdy, 1);
    b_ordy = 1;
    chk("R6 b little order", b_odata, 16'hA1B2);
    @(negedge clk);
    chk("R2 b second", b_odata, 16'hC3D4);
    @(negedge clk);
    b_ordy = 0;
    chk("R8 b discarded", b_ovalid, 0);
    @(negedge clk);
    chk("R8 b sticky", b_ovf, 1);

    // ---- Instance C ----
    c_data = 16'h1234; c_ordy = 0; c_valid = 0;
    do_reset();
    chk("R1 c ready", c_rdy, 0);
    @(negedge clk);
    chk("R9 c ready up", c_rdy, 1);
    chk("R9 c nothing yet", c_ovalid, 0);
    @(negedge clk);
    chk("R9 c taken w/o valid", c_ovalid, 1);
    chk("R9 c data", c_odata, 16'h1234);
    chk("R9 c ready full", c_rdy, 0);
    c_data = 16'h5678; c_ordy = 1;
    @(negedge clk);
    c_ordy = 0;
    chk("R9 c popped", c_ovalid, 0);
    chk("R9 c ready again", c_rdy, 1);
    @(negedge clk);
    chk("R9 c second data", c_odata, 16'h5678);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R2 act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule